// File: doc/BRIEF.md
# Privileged Instruction Permission Checker

This block sits beside the decode stage of a processor core that supports a hypervisor layer. For each cycle it looks at the class of the privileged instruction being decoded: wait-for-interrupt, address-translation fence, hypervisor fence, hypervisor virtual-machine load or hypervisor virtual-machine store. It compares that class against the current privilege mode, the virtualization-enabled flag and three trap-control bits. The first bit traps waits in supervisor mode, the second traps virtual-memory management in supervisor mode, and the third lets user mode issue hypervisor accesses. The block then raises exactly one result: the matching allow strobe (halt, flush, hypervisor flush, or a load or store request) or an illegal-instruction exception.

For an allowed hypervisor access, the block asserts a two-stage-lookup flag for the same cycle as the request and forwards the access size. Signedness is forwarded only for loads. One registered bit, the halted flag, is set by an allowed wait-for-interrupt. It is cleared by any pending interrupt, whether or not that interrupt is enabled. The translation structures and the memory accesses themselves are outside this block.

Top module: `priv_perm_check`

## Requirements
- R1: Wait-for-interrupt (class bit 0) is illegal when the mode is supervisor (1) with the wait-trap bit set, or whenever virtualization is enabled; otherwise haltReq is asserted.
- R2: The translation fence (class bit 1) is illegal in any mode other than supervisor (1) and machine (3), and in supervisor mode when the vm-trap bit is set; otherwise flushReq is asserted.
- R3: The hypervisor fence (class bit 2) is allowed only in machine mode, or in supervisor mode with virtualization disabled; otherwise it is illegal.
- R4: Hypervisor loads (class bit 3) and stores (class bit 4) are allowed in machine mode, in supervisor mode with virtualization off, or in user-level mode (0 or 2) with virtualization off and the user-hypervisor bit set; otherwise they are illegal.
- R5: twoStageLookup is high exactly while an allowed hypervisor load or store request is high. accSizeOut carries accSizeIn (0 byte, 1 halfword, 2 word, 3 doubleword) during such a request and is 0 otherwise. accSignedOut carries accSignedIn only for an allowed load and is 0 for stores.
- R6: When instClass is zero or has more than one bit set, every combinational output is low.
- R7: illegalInst and the allow strobes are mutually exclusive, and at most one allow strobe is high.
- R8: coreHalted rises on the clock edge after an allowed wait-for-interrupt and holds its value while no interrupt is pending.
- R9: coreHalted is low on the edge after any irqPending bit is high, whatever the class input is in that cycle.
- R10: After reset coreHalted is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| curMode | input | 2 | Privilege mode: 0 user, 1 supervisor, 3 machine, 2 treated as user |
| virtEnabled | input | 1 | Virtualization currently enabled |
| trapWaitBit | input | 1 | Trap wait-for-interrupt in supervisor mode |
| trapVmBit | input | 1 | Trap translation fence in supervisor mode |
| userHypBit | input | 1 | Allow hypervisor accesses from user mode |
| instClass | input | 5 | One-hot instruction class |
| accSizeIn | input | 2 | Access size of a hypervisor load or store |
| accSignedIn | input | 1 | Signed variant of a hypervisor load |
| irqPending | input | NUM_IRQ | Pending interrupt lines |
| haltReq | output | 1 | Allowed wait-for-interrupt |
| flushReq | output | 1 | Allowed translation fence |
| hypFlushReq | output | 1 | Allowed hypervisor fence |
| hypLoadReq | output | 1 | Allowed hypervisor load |
| hypStoreReq | output | 1 | Allowed hypervisor store |
| twoStageLookup | output | 1 | Two-stage translation for the current access |
| accSizeOut | output | 2 | Forwarded access size |
| accSignedOut | output | 1 | Forwarded load signedness |
| illegalInst | output | 1 | Illegal-instruction exception |
| coreHalted | output | 1 | Registered halted flag |

## Verification
The bench builds the block with the default four interrupt lines and a two-bit size field. This keeps the whole input space for the legality logic small enough to enumerate. Every mode, including the reserved encoding, is crossed with every setting of the virtualization flag, the three trap bits, every size and signedness, and the no-class, single-class and multi-class patterns. The halted flag is then driven through set, hold and clear sequences, each interrupt line in turn, and a same-cycle conflict between a wait and a pending interrupt.

// File: rtl/priv_perm_pkg.sv
package priv_perm_pkg;
  localparam int CLASS_W   = 5;
  localparam int CL_WFI    = 0;
  localparam int CL_FENCE  = 1;
  localparam int CL_HFENCE = 2;
  localparam int CL_HLOAD  = 3;
  localparam int CL_HSTORE = 4;

  localparam logic [1:0] MODE_SUP  = 2'd1;
  localparam logic [1:0] MODE_MACH = 2'd3;

  typedef struct packed {
    logic wfiOk;
    logic fenceOk;
    logic hfenceOk;
    logic loadOk;
    logic storeOk;
    logic illegal;
  } permStrobe_t;
endpackage

// File: rtl/priv_perm_ctrl.sv
module priv_perm_ctrl
  import priv_perm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         curMode,
  input  logic               virtEnabled,
  input  logic               trapWaitBit,
  input  logic               trapVmBit,
  input  logic               userHypBit,
  input  logic [CLASS_W-1:0] instClass,
  output permStrobe_t        strobes
);
  logic isMach, isSup, isUser, classValid;
  logic wfiLegal, fenceLegal, hfenceLegal, hypLegal;
  logic [CLASS_W-1:0] legalVec, activeVec;

  assign isMach     = (curMode == MODE_MACH);
  assign isSup      = (curMode == MODE_SUP);
  assign isUser     = !isMach && !isSup;
  assign classValid = $onehot(instClass);

  assign wfiLegal    = !((isSup && trapWaitBit) || virtEnabled);
  assign fenceLegal  = (isMach || isSup) && !(isSup && trapVmBit);
  assign hfenceLegal = isMach || (isSup && !virtEnabled);
  assign hypLegal    = isMach || (isSup && !virtEnabled) ||
                       (isUser && !virtEnabled && userHypBit);

  assign legalVec[CL_WFI]    = wfiLegal;
  assign legalVec[CL_FENCE]  = fenceLegal;
  assign legalVec[CL_HFENCE] = hfenceLegal;
  assign legalVec[CL_HLOAD]  = hypLegal;
  assign legalVec[CL_HSTORE] = hypLegal;

  for (genvar gi = 0; gi < CLASS_W; gi++) begin : g_gate
    assign activeVec[gi] = classValid && instClass[gi] && legalVec[gi];
  end

  always_comb begin
    strobes.wfiOk    = activeVec[CL_WFI];
    strobes.fenceOk  = activeVec[CL_FENCE];
    strobes.hfenceOk = activeVec[CL_HFENCE];
    strobes.loadOk   = activeVec[CL_HLOAD];
    strobes.storeOk  = activeVec[CL_HSTORE];
    strobes.illegal  = classValid && ((instClass & ~legalVec) != '0);
  end

  // R7: exception never coexists with any allow strobe
  p_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.illegal |-> !(strobes.wfiOk || strobes.fenceOk || strobes.hfenceOk ||
                          strobes.loadOk || strobes.storeOk));
  // R7: at most one result per cycle
  p_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wfiOk, strobes.fenceOk, strobes.hfenceOk,
              strobes.loadOk, strobes.storeOk, strobes.illegal}));
  // R2: supervisor fence with vm trap is an exception
  p_fence_trap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (instClass == (CLASS_W'(1) << CL_FENCE) && isSup && trapVmBit) |-> strobes.illegal);
  // R3: hypervisor fence never allowed with virtualization on outside machine mode
  p_hfence_virt_r3: assert property (@(posedge clk) disable iff (!rstN)
    (virtEnabled && !isMach) |-> !strobes.hfenceOk);
  // R6: no class, no result
  p_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (instClass == '0) |-> (strobes == '0));
endmodule

// File: rtl/priv_perm_dp.sv
module priv_perm_dp
  import priv_perm_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int SIZE_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  permStrobe_t        strobes,
  input  logic [SIZE_W-1:0]  accSizeIn,
  input  logic               accSignedIn,
  input  logic [NUM_IRQ-1:0] irqPending,
  output logic               twoStageLookup,
  output logic [SIZE_W-1:0]  accSizeOut,
  output logic               accSignedOut,
  output logic               coreHalted
);
  logic accessActive, anyIrq;

  assign accessActive   = strobes.loadOk || strobes.storeOk;
  assign anyIrq         = |irqPending;
  assign twoStageLookup = accessActive;
  assign accSizeOut     = accessActive ? accSizeIn : '0;
  assign accSignedOut   = strobes.loadOk && accSignedIn;

  always_ff @(posedge clk) begin
    if (!rstN)                coreHalted <= 1'b0;
    else if (anyIrq)          coreHalted <= 1'b0;
    else if (strobes.wfiOk)   coreHalted <= 1'b1;
  end

  // R8: allowed wait with nothing pending halts on the next edge
  p_halt_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wfiOk && !anyIrq) |=> coreHalted);
  // R8: flag holds when neither event occurs
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.wfiOk && !anyIrq) |=> $stable(coreHalted));
  // R9: any pending line wakes the core
  p_halt_clr_r9: assert property (@(posedge clk) disable iff (!rstN)
    anyIrq |=> !coreHalted);
  // R5: stores never report signedness
  p_store_unsigned_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.storeOk |-> !accSignedOut);
endmodule

// File: rtl/priv_perm_check.sv
module priv_perm_check
  import priv_perm_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int SIZE_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         curMode,
  input  logic               virtEnabled,
  input  logic               trapWaitBit,
  input  logic               trapVmBit,
  input  logic               userHypBit,
  input  logic [CLASS_W-1:0] instClass,
  input  logic [SIZE_W-1:0]  accSizeIn,
  input  logic               accSignedIn,
  input  logic [NUM_IRQ-1:0] irqPending,
  output logic               haltReq,
  output logic               flushReq,
  output logic               hypFlushReq,
  output logic               hypLoadReq,
  output logic               hypStoreReq,
  output logic               twoStageLookup,
  output logic [SIZE_W-1:0]  accSizeOut,
  output logic               accSignedOut,
  output logic               illegalInst,
  output logic               coreHalted
);
  permStrobe_t strobes;

  priv_perm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .curMode(curMode), .virtEnabled(virtEnabled),
    .trapWaitBit(trapWaitBit), .trapVmBit(trapVmBit), .userHypBit(userHypBit),
    .instClass(instClass), .strobes(strobes)
  );

  priv_perm_dp #(.NUM_IRQ(NUM_IRQ), .SIZE_W(SIZE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accSizeIn(accSizeIn),
    .accSignedIn(accSignedIn), .irqPending(irqPending),
    .twoStageLookup(twoStageLookup), .accSizeOut(accSizeOut),
    .accSignedOut(accSignedOut), .coreHalted(coreHalted)
  );

  assign haltReq     = strobes.wfiOk;
  assign flushReq    = strobes.fenceOk;
  assign hypFlushReq = strobes.hfenceOk;
  assign hypLoadReq  = strobes.loadOk;
  assign hypStoreReq = strobes.storeOk;
  assign illegalInst = strobes.illegal;
endmodule

// File: tb/priv_perm_check_tb.sv
module priv_perm_check_tb;
  localparam int NUM_IRQ = 4;
  localparam int SIZE_W  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] curMode = '0;
  logic virtEnabled = 0, trapWaitBit = 0, trapVmBit = 0, userHypBit = 0;
  logic [4:0] instClass = '0;
  logic [SIZE_W-1:0] accSizeIn = '0;
  logic accSignedIn = 0;
  logic [NUM_IRQ-1:0] irqPending = '0;
  logic haltReq, flushReq, hypFlushReq, hypLoadReq, hypStoreReq;
  logic twoStageLookup, accSignedOut, illegalInst, coreHalted;
  logic [SIZE_W-1:0] accSizeOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  priv_perm_check #(.NUM_IRQ(NUM_IRQ), .SIZE_W(SIZE_W)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Packed outputs: {halt,flush,hflush,load,store,twoStage,size,signed,illegal}
  function automatic logic [10:0] model(input logic [1:0] m, input logic v,
      input logic tw, input logic tvm, input logic hu, input logic [4:0] c,
      input logic [1:0] sz, input logic sg);
    logic isM, isS, isU, ok, wf, fe, hf, ld, st;
    isM = (m == 2'd3); isS = (m == 2'd1); isU = !isM && !isS;
    if ($countones(c) != 1) return '0;
    wf = c[0] && !((isS && tw) || v);
    fe = c[1] && (isM || isS) && !(isS && tvm);
    hf = c[2] && (isM || (isS && !v));
    ok = isM || (isS && !v) || (isU && !v && hu);
    ld = c[3] && ok;
    st = c[4] && ok;
    return {wf, fe, hf, ld, st, ld || st, (ld || st) ? sz : 2'b00, ld && sg,
            !(wf || fe || hf || ld || st)};
  endfunction

  function automatic string tagOf(input logic [4:0] c);
    if (c == 5'b00001) return "R1/R7";
    if (c == 5'b00010) return "R2/R7";
    if (c == 5'b00100) return "R3/R7";
    if (c == 5'b01000 || c == 5'b10000) return "R4/R5";
    return "R6";
  endfunction

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] pats [7];
    pats = '{5'b00000, 5'b00001, 5'b00010, 5'b00100, 5'b01000, 5'b10000, 5'b01010};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 halted after reset", 32'(coreHalted), 0);

    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 16; k++)
        for (int p = 0; p < 7; p++)
          for (int s = 0; s < 8; s++) begin
            @(negedge clk);
            curMode = 2'(m);
            {virtEnabled, trapWaitBit, trapVmBit, userHypBit} = 4'(k);
            instClass = pats[p];
            {accSizeIn, accSignedIn} = 3'(s);
            #1;
            check(tagOf(instClass),
              32'({haltReq, flushReq, hypFlushReq, hypLoadReq, hypStoreReq,
                   twoStageLookup, accSizeOut, accSignedOut, illegalInst}),
              32'(model(curMode, virtEnabled, trapWaitBit, trapVmBit, userHypBit,
                        instClass, accSizeIn, accSignedIn)));
          end

    // clear any halt left by the sweep
    @(negedge clk);
    instClass = '0; irqPending = 4'b0001;
    @(negedge clk);
    irqPending = '0;
    check("R9 cleared before halt tests", 32'(coreHalted), 0);

    // allowed wait in machine mode halts, then holds
    curMode = 2'd3; {virtEnabled, trapWaitBit, trapVmBit, userHypBit} = '0;
    instClass = 5'b00001;
    @(negedge clk);
    check("R8 halt set", 32'(coreHalted), 1);
    instClass = '0;
    repeat (3) @(negedge clk);
    check("R8 halt holds", 32'(coreHalted), 1);

    // each interrupt line wakes the core
    for (int i = 0; i < NUM_IRQ; i++) begin
      instClass = 5'b00001;
      @(negedge clk);
      check("R8 halt reset per line", 32'(coreHalted), 1);
      instClass = '0; irqPending = NUM_IRQ'(1) << i;
      @(negedge clk);
      irqPending = '0;
      check("R9 wake on line", 32'(coreHalted), 0);
    end

    // illegal wait (supervisor, wait trap) does not halt
    curMode = 2'd1; trapWaitBit = 1; instClass = 5'b00001;
    @(negedge clk);
    check("R1 trapped wait no halt", 32'(coreHalted), 0);
    trapWaitBit = 0; virtEnabled = 1;
    @(negedge clk);
    check("R1 virt wait no halt", 32'(coreHalted), 0);

    // wait and interrupt in the same cycle: interrupt wins
    virtEnabled = 0; irqPending = 4'b1000;
    @(negedge clk);
    check("R9 irq beats wait", 32'(coreHalted), 0);
    irqPending = '0; instClass = '0;
    @(negedge clk);
    check("R8 no late halt", 32'(coreHalted), 0);

    // user-mode wait is allowed
    curMode = 2'd0; instClass = 5'b00001;
    @(negedge clk);
    instClass = '0;
    check("R1 user wait halts", 32'(coreHalted), 1);

    // reset clears a set flag
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    check("R10 reset clears halt", 32'(coreHalted), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule